// File: doc/BRIEF.md
# Single-Level Page Table Walker

This block resolves a translation miss. When the translation cache cannot map a virtual page, it hands the walker the virtual page number, the page offset, the base of the current process's page table and the kind of access (read, write or instruction fetch). The walker computes where the matching entry sits in memory and fetches that one entry over a request/grant then response-valid handshake. It then decodes the entry.

An entry holds a physical page number and a few management bits; it never holds page data. A present entry that allows the access produces a refill for the translation cache: the physical page number, the flag bits and the physical address formed from the physical page number and the unchanged offset. A missing entry produces a page fault. A present entry that does not allow the access produces a protection fault. Each outcome is reported with a single-cycle completion pulse. A new miss is taken only when the walker is idle.

Top module: `pt_walker`

## Requirements
- R1: After reset `busy_o`, `mem_req_o`, `done_o`, `refill_valid_o`, `page_fault_o` and `prot_fault_o` are all low.
- R2: The entry address on `mem_addr_o` is `pt_base_i + miss_vpn_i*4`, modulo 2^36, taken from the inputs in the cycle the miss is accepted.
- R3: A miss (`miss_valid_i` high) is accepted only while `busy_o` is low. `busy_o` is high from the cycle after acceptance until the result cycle. A miss presented while busy is ignored and does not change the address, the result or the returned VPN.
- R4: `mem_req_o` goes high the cycle after acceptance and stays high, with `mem_addr_o` stable, until a cycle with `mem_gnt_i` high. The walker then waits any number of cycles for `mem_rvalid_i`, which carries the entry on `mem_rdata_i`.
- R5: Entry layout: bit 31 valid, bit 30 dirty, bit 29 referenced, bits 28:27 rights, bits 26:5 physical page number, bits 4:0 reserved and ignored. Rights bit 27 permits writes and bit 28 permits instruction fetches. Reads are always permitted on a valid entry.
- R6: A valid entry that permits the access gives, in the cycle after `mem_rvalid_i`: `done_o` and `refill_valid_o` high, `refill_ppn_o` = entry bits 26:5, `refill_flags_o` = {dirty, referenced, rights[28:27]}, `refill_vpn_o` = the accepted VPN and `phys_addr_o` = {PPN, accepted offset}.
- R7: An entry with bit 31 clear gives `page_fault_o` with `done_o`, with no refill, whatever its rights bits are.
- R8: Access encoding on `acc_type_i`: 00 read, 01 write, 10 fetch, 11 read. A write without bit 27, or a fetch without bit 28, on a valid entry gives `prot_fault_o` with `done_o` and no refill.
- R9: `done_o` is a one-cycle pulse, and `busy_o` is low in that cycle.
- R10: At most one of `refill_valid_o`, `page_fault_o` and `prot_fault_o` is high, each only together with `done_o`, and exactly one whenever `done_o` is high. Page fault takes precedence over protection fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| miss_valid_i | input | 1 | Translation miss request |
| miss_vpn_i | input | 26 | Virtual page number that missed |
| miss_off_i | input | 14 | Page offset of the access |
| acc_type_i | input | 2 | Access kind: 00 read, 01 write, 10 fetch, 11 read |
| pt_base_i | input | 36 | Physical base address of the page table |
| busy_o | output | 1 | Walk in progress |
| mem_req_o | output | 1 | Entry read request |
| mem_addr_o | output | 36 | Entry address |
| mem_gnt_i | input | 1 | Request accepted by memory |
| mem_rvalid_i | input | 1 | Entry data valid |
| mem_rdata_i | input | 32 | Entry data |
| done_o | output | 1 | Result pulse |
| refill_valid_o | output | 1 | Translation available for refill |
| refill_vpn_o | output | 26 | VPN of the refill |
| refill_ppn_o | output | 22 | Physical page number of the refill |
| refill_flags_o | output | 4 | {dirty, referenced, fetch right, write right} |
| phys_addr_o | output | 36 | Translated physical address |
| page_fault_o | output | 1 | Entry not valid |
| prot_fault_o | output | 1 | Access not permitted by the entry |

## Verification
The checker assumes that the memory side behaves: `mem_rvalid_i` is raised only after a grant, once per request. It also assumes that `mem_gnt_i` is meaningful only while `mem_req_o` is high. Under those conditions it checks that the request holds steady, that the pulse is single, and that the outcomes exclude each other. The bench drives grant and response strictly in that order and once per walk. It delays the grant by several cycles in some scenarios. It presents a stray miss only while a walk is running, and never in the result cycle, so every ignored request falls inside the busy window.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;
  typedef enum logic [1:0] {
    ACC_READ  = 2'b00,
    ACC_WRITE = 2'b01,
    ACC_EXEC  = 2'b10,
    ACC_READ2 = 2'b11
  } acc_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } walk_st_e;

  typedef enum logic [1:0] {
    RES_OK    = 2'd0,
    RES_PGF   = 2'd1,
    RES_PROT  = 2'd2
  } res_e;
endpackage

// File: rtl/pt_addr_gen.sv
module pt_addr_gen #(
  parameter int VPN_W    = 26,
  parameter int PA_W     = 36,
  parameter int ENT_LOG2 = 2
) (
  input  logic [VPN_W-1:0] vpn_i,
  input  logic [PA_W-1:0]  base_i,
  output logic [PA_W-1:0]  addr_o
);
  localparam int IDX_W = VPN_W + ENT_LOG2;

  logic [IDX_W-1:0] byte_idx;

  assign byte_idx = {vpn_i, {ENT_LOG2{1'b0}}};
  assign addr_o   = base_i + PA_W'(byte_idx);
endmodule

// File: rtl/pt_entry_check.sv
module pt_entry_check
  import pt_walker_pkg::*;
#(
  parameter int PTE_W = 32,
  parameter int PPN_W = 22
) (
  input  logic [PTE_W-1:0] pte_i,
  input  acc_e             acc_i,
  output logic [PPN_W-1:0] ppn_o,
  output logic [3:0]       flags_o,
  output res_e             res_o
);
  localparam int V_BIT   = PTE_W - 1;
  localparam int D_BIT   = PTE_W - 2;
  localparam int A_BIT   = PTE_W - 3;
  localparam int X_BIT   = PTE_W - 4;
  localparam int W_BIT   = PTE_W - 5;
  localparam int PPN_TOP = PTE_W - 6;
  localparam int RSV_W   = PTE_W - 5 - PPN_W;

  logic allowed;

  generate
    if (RSV_W > 0) begin : g_rsv
      logic unused_rsvd;
      assign unused_rsvd = ^pte_i[RSV_W-1:0];
    end
  endgenerate

  assign ppn_o   = pte_i[PPN_TOP -: PPN_W];
  assign flags_o = {pte_i[D_BIT], pte_i[A_BIT], pte_i[X_BIT], pte_i[W_BIT]};

  always_comb begin
    unique case (acc_i)
      ACC_WRITE: allowed = pte_i[W_BIT];
      ACC_EXEC:  allowed = pte_i[X_BIT];
      default:   allowed = 1'b1;
    endcase
  end

  always_comb begin
    if (!pte_i[V_BIT])  res_o = RES_PGF;
    else if (!allowed)  res_o = RES_PROT;
    else                res_o = RES_OK;
  end
endmodule

// File: rtl/pt_walk_fsm.sv
module pt_walk_fsm
  import pt_walker_pkg::*;
#(
  parameter int VPN_W = 26,
  parameter int OFF_W = 14,
  parameter int PPN_W = 22,
  parameter int PA_W  = 36
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             miss_valid_i,
  input  logic [VPN_W-1:0] miss_vpn_i,
  input  logic [OFF_W-1:0] miss_off_i,
  input  acc_e             acc_i,
  input  logic [PA_W-1:0]  addr_d_i,
  input  logic             mem_gnt_i,
  input  logic             mem_rvalid_i,
  input  res_e             res_i,
  input  logic [PPN_W-1:0] ppn_i,
  input  logic [3:0]       flags_i,
  output acc_e             acc_q_o,
  output logic             busy_o,
  output logic             mem_req_o,
  output logic [PA_W-1:0]  mem_addr_o,
  output logic             done_o,
  output logic             refill_valid_o,
  output logic [VPN_W-1:0] refill_vpn_o,
  output logic [PPN_W-1:0] refill_ppn_o,
  output logic [3:0]       refill_flags_o,
  output logic [PA_W-1:0]  phys_addr_o,
  output logic             page_fault_o,
  output logic             prot_fault_o
);
  walk_st_e         st_q, st_d;
  logic [VPN_W-1:0] vpn_q;
  logic [OFF_W-1:0] off_q;
  acc_e             acc_q;
  logic [PA_W-1:0]  addr_q;
  logic             accept, resp;

  assign accept = (st_q == ST_IDLE) && miss_valid_i;
  assign resp   = (st_q == ST_WAIT) && mem_rvalid_i;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (miss_valid_i) st_d = ST_REQ;
      ST_REQ:  if (mem_gnt_i)    st_d = ST_WAIT;
      ST_WAIT: if (mem_rvalid_i) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      vpn_q  <= '0;
      off_q  <= '0;
      acc_q  <= ACC_READ;
      addr_q <= '0;
    end else begin
      st_q <= st_d;
      if (accept) begin
        vpn_q  <= miss_vpn_i;
        off_q  <= miss_off_i;
        acc_q  <= acc_i;
        addr_q <= addr_d_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o         <= 1'b0;
      refill_valid_o <= 1'b0;
      page_fault_o   <= 1'b0;
      prot_fault_o   <= 1'b0;
      refill_vpn_o   <= '0;
      refill_ppn_o   <= '0;
      refill_flags_o <= '0;
      phys_addr_o    <= '0;
    end else begin
      done_o         <= resp;
      refill_valid_o <= resp && (res_i == RES_OK);
      page_fault_o   <= resp && (res_i == RES_PGF);
      prot_fault_o   <= resp && (res_i == RES_PROT);
      if (resp && (res_i == RES_OK)) begin
        refill_vpn_o   <= vpn_q;
        refill_ppn_o   <= ppn_i;
        refill_flags_o <= flags_i;
        phys_addr_o    <= {ppn_i, off_q};
      end
    end
  end

  assign acc_q_o    = acc_q;
  assign busy_o     = (st_q != ST_IDLE);
  assign mem_req_o  = (st_q == ST_REQ);
  assign mem_addr_o = addr_q;
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walker_pkg::*;
#(
  parameter int VPN_W    = 26,
  parameter int OFF_W    = 14,
  parameter int PPN_W    = 22,
  parameter int PTE_W    = 32,
  parameter int ENT_LOG2 = 2,
  localparam int PA_W    = PPN_W + OFF_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             miss_valid_i,
  input  logic [VPN_W-1:0] miss_vpn_i,
  input  logic [OFF_W-1:0] miss_off_i,
  input  logic [1:0]       acc_type_i,
  input  logic [PA_W-1:0]  pt_base_i,
  output logic             busy_o,
  output logic             mem_req_o,
  output logic [PA_W-1:0]  mem_addr_o,
  input  logic             mem_gnt_i,
  input  logic             mem_rvalid_i,
  input  logic [PTE_W-1:0] mem_rdata_i,
  output logic             done_o,
  output logic             refill_valid_o,
  output logic [VPN_W-1:0] refill_vpn_o,
  output logic [PPN_W-1:0] refill_ppn_o,
  output logic [3:0]       refill_flags_o,
  output logic [PA_W-1:0]  phys_addr_o,
  output logic             page_fault_o,
  output logic             prot_fault_o
);
  logic [PA_W-1:0]  addr_d;
  logic [PPN_W-1:0] chk_ppn;
  logic [3:0]       chk_flags;
  res_e             chk_res;
  acc_e             acc_q;

  pt_addr_gen #(
    .VPN_W(VPN_W), .PA_W(PA_W), .ENT_LOG2(ENT_LOG2)
  ) u_addr (
    .vpn_i(miss_vpn_i), .base_i(pt_base_i), .addr_o(addr_d)
  );

  pt_entry_check #(
    .PTE_W(PTE_W), .PPN_W(PPN_W)
  ) u_check (
    .pte_i(mem_rdata_i), .acc_i(acc_q),
    .ppn_o(chk_ppn), .flags_o(chk_flags), .res_o(chk_res)
  );

  pt_walk_fsm #(
    .VPN_W(VPN_W), .OFF_W(OFF_W), .PPN_W(PPN_W), .PA_W(PA_W)
  ) u_fsm (
    .clk_i, .rst_ni, .miss_valid_i, .miss_vpn_i, .miss_off_i,
    .acc_i(acc_e'(acc_type_i)), .addr_d_i(addr_d),
    .mem_gnt_i, .mem_rvalid_i,
    .res_i(chk_res), .ppn_i(chk_ppn), .flags_i(chk_flags),
    .acc_q_o(acc_q),
    .busy_o, .mem_req_o, .mem_addr_o, .done_o, .refill_valid_o,
    .refill_vpn_o, .refill_ppn_o, .refill_flags_o, .phys_addr_o,
    .page_fault_o, .prot_fault_o
  );
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
  parameter int PA_W = 36
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            miss_valid_i,
  input logic            busy_o,
  input logic            mem_req_o,
  input logic [PA_W-1:0] mem_addr_o,
  input logic            mem_gnt_i,
  input logic            done_o,
  input logic            refill_valid_o,
  input logic            page_fault_o,
  input logic            prot_fault_o
);
  // R4
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_gnt_i) |=> (mem_req_o && $stable(mem_addr_o)));
  // R3
  req_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> busy_o);
  // R3
  busy_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(miss_valid_i));
  // R9
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R9
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  // R9
  busy_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);
  // R10
  excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({refill_valid_o, page_fault_o, prot_fault_o}));
  // R10
  outcome_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o == ($countones({refill_valid_o, page_fault_o, prot_fault_o}) == 1));
endmodule

bind pt_walker pt_walker_chk #(.PA_W(PA_W)) u_pt_walker_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .miss_valid_i(miss_valid_i),
  .busy_o(busy_o), .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
  .mem_gnt_i(mem_gnt_i), .done_o(done_o), .refill_valid_o(refill_valid_o),
  .page_fault_o(page_fault_o), .prot_fault_o(prot_fault_o)
);

// File: tb/tb_pt_walker.sv
module tb_pt_walker;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        miss_valid_i = 1'b0;
  logic [25:0] miss_vpn_i = '0;
  logic [13:0] miss_off_i = '0;
  logic [1:0]  acc_type_i = '0;
  logic [35:0] pt_base_i = '0;
  logic        mem_gnt_i = 1'b0;
  logic        mem_rvalid_i = 1'b0;
  logic [31:0] mem_rdata_i = '0;
  logic        busy_o, mem_req_o, done_o, refill_valid_o, page_fault_o, prot_fault_o;
  logic [35:0] mem_addr_o, phys_addr_o;
  logic [25:0] refill_vpn_o;
  logic [21:0] refill_ppn_o;
  logic [3:0]  refill_flags_o;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #10 clk_i = ~clk_i;

  pt_walker dut (.*);

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_pte(bit v, bit d, bit a, bit x, bit w, logic [21:0] ppn);
    return {v, d, a, x, w, ppn, 5'b10101};
  endfunction

  // One walk; expected values are derived from the entry fields per R5..R8.
  task automatic walk(logic [25:0] vpn, logic [13:0] off, logic [35:0] base,
                      logic [1:0] acc, logic [31:0] pte, int gnt_dly, bit stray);
    logic [35:0] exp_addr;
    bit ok_acc, exp_pgf, exp_prot, exp_ok;
    exp_addr = base + {8'h0, vpn, 2'b00};
    ok_acc   = (acc == 2'b01) ? pte[27] : (acc == 2'b10) ? pte[28] : 1'b1;
    exp_pgf  = !pte[31];
    exp_prot = pte[31] && !ok_acc;
    exp_ok   = pte[31] && ok_acc;
    @(negedge clk_i);
    miss_vpn_i = vpn; miss_off_i = off; acc_type_i = acc; pt_base_i = base;
    miss_valid_i = 1'b1;
    @(negedge clk_i);
    if (stray) begin
      miss_vpn_i = ~vpn; pt_base_i = base + 36'h100; acc_type_i = 2'b00;
    end else miss_valid_i = 1'b0;
    chk("R3 busy after accept", busy_o, 1);
    chk("R4 req after accept", mem_req_o, 1);
    chk("R2 entry address", mem_addr_o, exp_addr);
    for (int i = 0; i < gnt_dly; i++) begin
      @(negedge clk_i);
      chk("R4 req held", mem_req_o, 1);
      chk("R3 R4 addr stable", mem_addr_o, exp_addr);
    end
    mem_gnt_i = 1'b1;
    @(negedge clk_i);
    mem_gnt_i = 1'b0;
    chk("R4 req drops after grant", mem_req_o, 0);
    chk("R3 busy while waiting", busy_o, 1);
    @(negedge clk_i);
    chk("R4 wait for rvalid", done_o, 0);
    miss_valid_i = 1'b0;
    mem_rvalid_i = 1'b1; mem_rdata_i = pte;
    @(negedge clk_i);
    mem_rvalid_i = 1'b0; mem_rdata_i = '0;
    chk("R9 done", done_o, 1);
    chk("R9 busy low at done", busy_o, 0);
    chk("R6 refill_valid", refill_valid_o, exp_ok);
    chk("R7 page fault", page_fault_o, exp_pgf);
    chk("R8 prot fault", prot_fault_o, exp_prot);
    if (exp_ok) begin
      chk("R6 R5 ppn", refill_ppn_o, pte[26:5]);
      chk("R6 R5 flags", refill_flags_o, pte[30:27]);
      chk("R6 R3 vpn", refill_vpn_o, vpn);
      chk("R6 phys addr", phys_addr_o, {pte[26:5], off});
    end
    @(negedge clk_i);
    chk("R9 done single pulse", done_o, 0);
    chk("R10 no result without done", refill_valid_o | page_fault_o | prot_fault_o, 0);
  endtask

  task automatic t_reset();
    chk("R1 busy", busy_o, 0);
    chk("R1 req", mem_req_o, 0);
    chk("R1 done", done_o, 0);
    chk("R1 outcomes", {refill_valid_o, page_fault_o, prot_fault_o}, 0);
  endtask

  task automatic t_read_ok();
    walk(26'h0000123, 14'h0abc, 36'h0_4000_0000, 2'b00,
         mk_pte(1, 0, 1, 0, 0, 22'h12345), 0, 0);
  endtask

  task automatic t_write_ok();
    walk(26'h1234567, 14'h3fff, 36'h8_0000_1000, 2'b01,
         mk_pte(1, 1, 1, 0, 1, 22'h3ffffe), 2, 0);
  endtask

  task automatic t_exec_ok();
    walk(26'h0000001, 14'h0000, 36'h0_0000_0000, 2'b10,
         mk_pte(1, 0, 0, 1, 0, 22'h000001), 1, 0);
  endtask

  task automatic t_read2_ok();
    walk(26'h2aaaaaa, 14'h1555, 36'h1_2345_6000, 2'b11,
         mk_pte(1, 0, 0, 0, 0, 22'h2aaaaa), 0, 0);
  endtask

  task automatic t_write_prot();
    walk(26'h0000040, 14'h0010, 36'h0_1000_0000, 2'b01,
         mk_pte(1, 0, 1, 1, 0, 22'h000fff), 0, 0);
  endtask

  task automatic t_exec_prot();
    walk(26'h0000041, 14'h0020, 36'h0_1000_0000, 2'b10,
         mk_pte(1, 1, 1, 0, 1, 22'h000eee), 0, 0);
  endtask

  task automatic t_invalid();
    walk(26'h0000042, 14'h0030, 36'h0_1000_0000, 2'b01,
         mk_pte(0, 1, 1, 1, 1, 22'h3fffff), 0, 0);
  endtask

  task automatic t_busy_stray();
    walk(26'h0abcdef, 14'h0777, 36'h0_2000_0000, 2'b01,
         mk_pte(1, 0, 0, 0, 1, 22'h155555), 3, 1);
    chk("R3 no stray walk", busy_o, 0);
  endtask

  task automatic t_boundary();
    walk(26'h3ffffff, 14'h3fff, 36'hf_f000_0000, 2'b00,
         mk_pte(1, 1, 1, 1, 1, 22'h3fffff), 0, 0);
    walk(26'h3ffffff, 14'h0001, 36'hf_ffff_fff0, 2'b00,
         mk_pte(1, 0, 0, 0, 0, 22'h000000), 0, 0);
  endtask

  initial begin
    #35 t_reset();
    @(negedge clk_i) rst_ni = 1'b1;
    t_reset();
    t_read_ok();
    t_write_ok();
    t_exec_ok();
    t_read2_ok();
    t_write_prot();
    t_exec_prot();
    t_invalid();
    t_busy_stray();
    t_boundary();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!finished) begin
      finished = 1;
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule